// File: doc/BRIEF.md
# Phase-Encoding Line Modem

This block sits between a bit-oriented serial link controller and a two-level line driver and receiver. On the transmit side it takes one data bit per bit period from the controller. It turns each bit into a Manchester symbol with a guaranteed transition in the middle of the bit, and drives that symbol onto the line. On the receive side it oversamples the incoming line with the master clock and locks onto the mid-bit transitions. It returns each recovered bit to the controller together with a regenerated bit clock.

All timing comes from one 16 MHz master clock. A single select input picks one of two line rates. The fast rate uses a whole number of clocks per bit. The slow rate uses a fractional divide: most bits are one length and every third bit is one clock longer, so the average bit time comes out exact. The receiver accepts a transition as mid-bit only when it falls inside a quarter-bit window around the expected point. When the line goes quiet for two bit times, it reports loss of signal.

Top module: `pe_line_modem`

## Requirements
- R1: While reset is asserted, line_tx, rx_data, rx_clk and tx_bit_start are 0 and rx_los is 1.
- R2: Each transmitted bit is a Manchester symbol. A 1 drives high for the first floor(N/2) clocks of the bit and low for the rest. A 0 drives low and then high. N is the length of that bit in clocks, and line_tx shows the symbol starting one clock after the clock that sampled tx_data.
- R3: With rate_sel = 0, every bit lasts exactly FAST_BIT_CLKS (16) master clocks.
- R4: With rate_sel = 1, bit lengths count from the enable in the repeating order 33, 33, 34 clocks. This is SLOW_BIT_CLKS plus one extra clock whenever the 1/3 fraction accumulator wraps.
- R5: tx_bit_start is a single-clock pulse in the first clock of every bit. tx_data is sampled on that clock.
- R6: While tx_en is 0, line_tx is held low. The clock after tx_en rises is always the first clock of a new bit.
- R7: A recovered bit equals the line level just before an accepted mid-bit transition: falling gives 1, rising gives 0. rx_data changes one clock before rx_clk rises. rx_clk then stays high for floor(L/2) clocks, where L is the nominal bit length.
- R8: Lock needs two transitions whose spacing lies inside the window. For a burst that starts 0, 1 from an idle-low line, the received sequence equals the sent sequence from its second bit on.
- R9: Once locked, a transition that comes less than L − floor(L/4) or more than L + floor(L/4) clocks after the last accepted mid-bit transition is ignored. Such a transition changes neither the data nor the lock.
- R10: rx_los falls when lock is gained. It rises when no mid-bit transition has been accepted for 2·L clocks. While rx_los is 1, rx_clk stays low.
- R11: The receiver uses a nominal L of 16 clocks when rate_sel = 0 and 33 clocks when rate_sel = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 1 | 0 selects the fast line rate, 1 the slow one; change only while idle |
| tx_en | input | 1 | Transmitter enable |
| tx_data | input | 1 | Serial data from the link controller |
| tx_bit_start | output | 1 | One-clock pulse: tx_data is taken on this clock |
| line_tx | output | 1 | Manchester symbol stream to the line driver |
| line_rx | input | 1 | Asynchronous symbol stream from the line receiver |
| rx_data | output | 1 | Recovered data bit |
| rx_clk | output | 1 | Regenerated receive bit clock |
| rx_los | output | 1 | Loss of signal |

## Verification
The bench builds the block with its default parameters: 16 clocks per fast bit, 33 per slow bit, and a one-third stretch fraction. With these values the 34-clock stretched bit appears every third bit, so a burst of a few dozen bits passes through every length and window edge many times. Loopback bursts at both rates check the transmit waveform sample by sample against an arithmetic model. Driven waveforms with short glitches placed off the mid-bit point show the acceptance window. The silence after each burst shows the two-bit loss-of-signal timeout.

// File: rtl/pe_modem_pkg.sv
package pe_modem_pkg;

   typedef enum logic {
      RATE_FAST = 1'b0,
      RATE_SLOW = 1'b1
   } line_rate_e;

   // Earliest accepted spacing between mid-bit transitions
   function automatic int win_lo(input int nominal);
      return nominal - nominal / 4;
   endfunction

   // Latest accepted spacing between mid-bit transitions
   function automatic int win_hi(input int nominal);
      return nominal + nominal / 4;
   endfunction

endpackage

// File: rtl/pe_bit_timer.sv
module pe_bit_timer #(
   parameter int FAST_BIT_CLKS = 16,
   parameter int SLOW_BIT_CLKS = 33,
   parameter int SLOW_FRAC_NUM = 1,
   parameter int SLOW_FRAC_DEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic rate_slow,
   output logic bit_start,
   output logic second_half
);
   localparam int CW = $clog2(SLOW_BIT_CLKS + 2);
   localparam logic [CW-1:0] FAST_M1  = CW'(FAST_BIT_CLKS - 1);
   localparam logic [CW-1:0] SLOW_M1  = CW'(SLOW_BIT_CLKS - 1);
   localparam logic [CW-1:0] LONG_M1  = CW'(SLOW_BIT_CLKS);
   localparam logic [CW-1:0] FAST_HLF = CW'(FAST_BIT_CLKS / 2);
   localparam logic [CW-1:0] SLOW_HLF = CW'(SLOW_BIT_CLKS / 2);
   localparam logic [CW-1:0] LONG_HLF = CW'((SLOW_BIT_CLKS + 1) / 2);

   logic [CW-1:0] cnt;
   logic          long_q;
   logic          long_now;
   logic          long_sel;
   logic [CW-1:0] len_m1;
   logic [CW-1:0] half_len;

   generate
      if (SLOW_FRAC_NUM > 0) begin : g_frac
         localparam int AW = $clog2(SLOW_FRAC_DEN + 1);
         localparam logic [AW-1:0] WRAP = AW'(SLOW_FRAC_DEN - SLOW_FRAC_NUM);
         localparam logic [AW-1:0] STEP = AW'(SLOW_FRAC_NUM);
         logic [AW-1:0] acc;

         assign long_now = (acc >= WRAP);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc <= '0;
            end else if (!en) begin
               acc <= '0;
            end else if (cnt == '0 && rate_slow) begin
               acc <= long_now ? (acc - WRAP) : (acc + STEP);
            end
         end
      end else begin : g_whole
         assign long_now = 1'b0;
      end
   endgenerate

   assign long_sel = (cnt == '0) ? long_now : long_q;

   always_comb begin
      if (!rate_slow) begin
         len_m1   = FAST_M1;
         half_len = FAST_HLF;
      end else if (long_sel) begin
         len_m1   = LONG_M1;
         half_len = LONG_HLF;
      end else begin
         len_m1   = SLOW_M1;
         half_len = SLOW_HLF;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         long_q <= 1'b0;
      end else if (!en) begin
         cnt    <= '0;
         long_q <= 1'b0;
      end else begin
         if (cnt == len_m1) cnt <= '0;
         else               cnt <= cnt + 1'b1;
         if (cnt == '0) long_q <= long_now;
      end
   end

   assign bit_start   = en && (cnt == '0);
   assign second_half = (cnt >= half_len);

endmodule

// File: rtl/pe_line_encoder.sv
module pe_line_encoder (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic bit_start,
   input  logic second_half,
   input  logic tx_data,
   output logic line_tx
);
   logic cur_bit;
   logic bit_now;

   assign bit_now = bit_start ? tx_data : cur_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_bit <= 1'b0;
         line_tx <= 1'b0;
      end else begin
         if (bit_start) cur_bit <= tx_data;
         if (!en)              line_tx <= 1'b0;
         else if (second_half) line_tx <= ~bit_now;
         else                  line_tx <= bit_now;
      end
   end

endmodule

// File: rtl/pe_line_decoder.sv
module pe_line_decoder
   import pe_modem_pkg::*;
#(
   parameter int FAST_BIT_CLKS = 16,
   parameter int SLOW_BIT_CLKS = 33,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_slow,
   input  logic line_rx,
   output logic rx_data,
   output logic rx_clk,
   output logic rx_los
);
   localparam int MW = $clog2(2 * SLOW_BIT_CLKS + 4);
   localparam logic [MW-1:0] LO_F   = MW'(win_lo(FAST_BIT_CLKS));
   localparam logic [MW-1:0] HI_F   = MW'(win_hi(FAST_BIT_CLKS));
   localparam logic [MW-1:0] LO_S   = MW'(win_lo(SLOW_BIT_CLKS));
   localparam logic [MW-1:0] HI_S   = MW'(win_hi(SLOW_BIT_CLKS));
   localparam logic [MW-1:0] DROP_F = MW'(2 * FAST_BIT_CLKS - 1);
   localparam logic [MW-1:0] DROP_S = MW'(2 * SLOW_BIT_CLKS - 1);
   localparam logic [MW-1:0] CEND_F = MW'(2 + FAST_BIT_CLKS / 2);
   localparam logic [MW-1:0] CEND_S = MW'(2 + SLOW_BIT_CLKS / 2);
   localparam logic [MW-1:0] CLK_BEG = MW'(2);
   localparam logic [MW-1:0] ONE    = MW'(1);
   localparam logic [MW-1:0] CMAX   = '1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   s_now;
   logic                   s_prev;
   logic                   edge_seen;
   logic [MW-1:0]          mid_cnt;
   logic                   locked;
   logic                   in_win;
   logic [MW-1:0]          lo, hi, drop, cend;

   generate
      genvar gi;
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sync_q[gi] <= 1'b0;
            else if (gi == 0) sync_q[gi] <= line_rx;
            else             sync_q[gi] <= sync_q[(gi == 0) ? 0 : gi - 1];
         end
      end
   endgenerate

   assign s_now     = sync_q[SYNC_STAGES-1];
   assign edge_seen = s_now ^ s_prev;

   assign lo   = rate_slow ? LO_S   : LO_F;
   assign hi   = rate_slow ? HI_S   : HI_F;
   assign drop = rate_slow ? DROP_S : DROP_F;
   assign cend = rate_slow ? CEND_S : CEND_F;

   assign in_win = (mid_cnt >= lo) && (mid_cnt <= hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_prev  <= 1'b0;
         mid_cnt <= CMAX;
         locked  <= 1'b0;
         rx_data <= 1'b0;
      end else begin
         s_prev <= s_now;
         if (edge_seen && in_win) begin
            locked  <= 1'b1;
            rx_data <= s_prev;
            mid_cnt <= ONE;
         end else begin
            if (edge_seen && !locked) mid_cnt <= ONE;
            else if (mid_cnt != CMAX) mid_cnt <= mid_cnt + 1'b1;
            if (mid_cnt >= drop) locked <= 1'b0;
         end
      end
   end

   assign rx_clk = locked && (mid_cnt >= CLK_BEG) && (mid_cnt < cend);
   assign rx_los = ~locked;

endmodule

// File: rtl/pe_line_modem.sv
module pe_line_modem
   import pe_modem_pkg::*;
#(
   parameter int FAST_BIT_CLKS = 16,
   parameter int SLOW_BIT_CLKS = 33,
   parameter int SLOW_FRAC_NUM = 1,
   parameter int SLOW_FRAC_DEN = 3,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_sel,
   input  logic tx_en,
   input  logic tx_data,
   output logic tx_bit_start,
   output logic line_tx,
   input  logic line_rx,
   output logic rx_data,
   output logic rx_clk,
   output logic rx_los
);
   generate
      if (FAST_BIT_CLKS < 8) begin : g_bad_fast
         $error("FAST_BIT_CLKS must be at least 8");
      end
      if (SLOW_BIT_CLKS < FAST_BIT_CLKS) begin : g_bad_slow
         $error("SLOW_BIT_CLKS must not be below FAST_BIT_CLKS");
      end
      if (SLOW_FRAC_DEN < 1 || SLOW_FRAC_NUM < 0 || SLOW_FRAC_NUM >= SLOW_FRAC_DEN) begin : g_bad_frac
         $error("slow fraction must satisfy 0 <= NUM < DEN");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   line_rate_e rate;
   logic       rate_slow;
   logic       second_half;

   assign rate      = line_rate_e'(rate_sel);
   assign rate_slow = (rate == RATE_SLOW);

   pe_bit_timer #(
      .FAST_BIT_CLKS (FAST_BIT_CLKS),
      .SLOW_BIT_CLKS (SLOW_BIT_CLKS),
      .SLOW_FRAC_NUM (SLOW_FRAC_NUM),
      .SLOW_FRAC_DEN (SLOW_FRAC_DEN)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (tx_en),
      .rate_slow   (rate_slow),
      .bit_start   (tx_bit_start),
      .second_half (second_half)
   );

   pe_line_encoder u_enc (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (tx_en),
      .bit_start   (tx_bit_start),
      .second_half (second_half),
      .tx_data     (tx_data),
      .line_tx     (line_tx)
   );

   pe_line_decoder #(
      .FAST_BIT_CLKS (FAST_BIT_CLKS),
      .SLOW_BIT_CLKS (SLOW_BIT_CLKS),
      .SYNC_STAGES   (SYNC_STAGES)
   ) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .rate_slow (rate_slow),
      .line_rx   (line_rx),
      .rx_data   (rx_data),
      .rx_clk    (rx_clk),
      .rx_los    (rx_los)
   );

endmodule

// File: rtl/pe_line_modem_sva.sv
module pe_line_modem_sva (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic tx_data,
   input logic tx_bit_start,
   input logic line_tx,
   input logic rx_data,
   input logic rx_clk,
   input logic rx_los
);
   // R6: disabled transmitter drives the line low
   a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> !line_tx);

   // R5: bit start only while enabled
   a_r5_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      tx_bit_start |-> tx_en);

   // R5: bit start lasts one clock
   a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_bit_start |=> !tx_bit_start);

   // R2: first half of the symbol equals the sampled bit
   a_r2_first_half: assert property (@(posedge clk) disable iff (!rst_n)
      tx_bit_start |=> (line_tx == $past(tx_data)));

   // R10: no receive clock while signal is lost
   a_r10_los_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rx_los |-> !rx_clk);

   // R7: recovered data steady while the receive clock is high
   a_r7_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_clk && $past(rx_clk)) |-> $stable(rx_data));

endmodule

bind pe_line_modem pe_line_modem_sva u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .tx_en        (tx_en),
   .tx_data      (tx_data),
   .tx_bit_start (tx_bit_start),
   .line_tx      (line_tx),
   .rx_data      (rx_data),
   .rx_clk       (rx_clk),
   .rx_los       (rx_los)
);

// File: tb/pe_line_modem_test.sv
module pe_line_modem_test;
   localparam int CLK_PERIOD = 10;
   localparam int FAST = 16;
   localparam int SLOW = 33;

   logic clk = 1'b0;
   logic rst_n, rate_sel, tx_en, tx_data, tx_bit_start, line_tx;
   logic line_rx, rx_data, rx_clk, rx_los;
   logic loop_sel, drv_rx;

   int  tests = 0;
   int  fails = 0;
   bit  done  = 1'b0;
   bit  sent [0:127];
   bit  rxq [$];

   bit  mon_en = 1'b0, mon_active = 1'b0, mon_d = 1'b0;
   int  mon_i = 0, mon_len = 0, mon_b = 0;
   bit  rx_prev = 1'b0;
   int  hi_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign line_rx = loop_sel ? line_tx : drv_rx;

   pe_line_modem uut (
      .clk (clk), .rst_n (rst_n), .rate_sel (rate_sel), .tx_en (tx_en),
      .tx_data (tx_data), .tx_bit_start (tx_bit_start), .line_tx (line_tx),
      .line_rx (line_rx), .rx_data (rx_data), .rx_clk (rx_clk), .rx_los (rx_los)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int bit_len(input bit slow, input int idx);
      if (!slow) return FAST;
      return (idx % 3 == 2) ? SLOW + 1 : SLOW;
   endfunction

   function automatic bit pat(input int kind, input int idx);
      if (idx == 0) return 1'b0;
      if (idx == 1) return 1'b1;
      case (kind)
         0:       return 1'b1;
         1:       return 1'b0;
         2:       return ((idx * 5 + idx / 3) % 7) < 3;
         default: return 1'(idx % 2);
      endcase
   endfunction

   // Transmit waveform model: R2, R3, R4
   always @(negedge clk) begin
      if (mon_en) begin
         if (mon_active) begin
            automatic bit exp = (mon_i < mon_len / 2) ? mon_d : ~mon_d;
            chk(line_tx === exp, "R2", int'(line_tx), int'(exp));
            mon_i++;
         end
         if (tx_bit_start) begin
            if (mon_active) chk(mon_i == mon_len, rate_sel ? "R4" : "R3", mon_i, mon_len);
            mon_len = bit_len(rate_sel, mon_b);
            mon_b++;
            mon_d = tx_data;
            mon_i = 0;
            mon_active = 1'b1;
         end
      end
   end

   // Receive clock collector: R7
   always @(negedge clk) begin
      if (rx_clk && !rx_prev) begin
         rxq.push_back(rx_data);
         hi_cnt = 1;
      end else if (rx_clk) begin
         hi_cnt++;
      end else if (rx_prev) begin
         chk(hi_cnt == (rate_sel ? SLOW : FAST) / 2, "R7", hi_cnt, (rate_sel ? SLOW : FAST) / 2);
      end
      rx_prev = rx_clk;
   end

   task automatic check_rx(input int n, input string tag);
      chk(rxq.size() == n - 1, tag, rxq.size(), n - 1);
      for (int j = 0; j < n - 1; j++) begin
         if (j < rxq.size()) chk(rxq[j] == sent[j + 1], "R7", int'(rxq[j]), int'(sent[j + 1]));
      end
   endtask

   task automatic quiet_check(input int nom);
      repeat (2 * nom + 10) @(negedge clk);
      chk(rx_los == 1'b1, "R10", int'(rx_los), 1);
      for (int k = 0; k < nom; k++) begin
         @(negedge clk);
         chk(rx_clk == 1'b0, "R10", int'(rx_clk), 0);
      end
   endtask

   task automatic tx_burst(input bit slow, input int n, input int kind);
      automatic int  nom   = slow ? SLOW : FAST;
      automatic int  idx   = 0;
      automatic bit  first = 1'b1;
      for (int i = 0; i < n; i++) sent[i] = pat(kind, i);
      rate_sel = slow;
      loop_sel = 1'b1;
      repeat (4) @(posedge clk);
      #1;
      rxq.delete();
      mon_b = 0; mon_active = 1'b0; mon_en = 1'b1;
      tx_data = sent[0];
      tx_en = 1'b1;
      while (idx < n) begin
         @(negedge clk);
         if (first) chk(tx_bit_start == 1'b1, "R6", int'(tx_bit_start), 1);
         first = 1'b0;
         if (tx_bit_start) begin
            idx++;
            @(posedge clk);
            #1 tx_data = (idx < n) ? sent[idx] : 1'b0;
            @(negedge clk);
            chk(tx_bit_start == 1'b0, "R5", int'(tx_bit_start), 0);
         end
      end
      while (!tx_bit_start) @(negedge clk);
      @(posedge clk);
      #1;
      mon_en = 1'b0;
      tx_en  = 1'b0;
      chk(rx_los == 1'b0, "R10", int'(rx_los), 0);
      for (int k = 0; k < nom; k++) begin
         @(negedge clk);
         chk(line_tx == 1'b0, "R6", int'(line_tx), 0);
      end
      quiet_check(nom);
      check_rx(n, slow ? "R11" : "R8");
   endtask

   task automatic rx_glitch(input int n);
      for (int i = 0; i < n; i++) sent[i] = pat(2, i);
      rate_sel = 1'b0;
      drv_rx   = 1'b0;
      loop_sel = 1'b0;
      repeat (4) @(posedge clk);
      rxq.delete();
      for (int b = 0; b < n; b++) begin
         for (int c = 0; c < FAST; c++) begin
            automatic bit v = (c < FAST / 2) ? sent[b] : ~sent[b];
            if (b >= 2 && b < n - 1 && (c == 12 || c == 13)) v = ~v;
            @(posedge clk);
            #1 drv_rx = v;
         end
      end
      @(posedge clk);
      #1 drv_rx = 1'b0;
      chk(rx_los == 1'b0, "R9", int'(rx_los), 0);
      quiet_check(FAST);
      check_rx(n, "R9");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; rate_sel = 1'b0; tx_en = 1'b0; tx_data = 1'b0;
      loop_sel = 1'b1; drv_rx = 1'b0;
      repeat (3) @(negedge clk);
      chk(line_tx == 1'b0,      "R1", int'(line_tx), 0);
      chk(rx_clk == 1'b0,       "R1", int'(rx_clk), 0);
      chk(rx_data == 1'b0,      "R1", int'(rx_data), 0);
      chk(rx_los == 1'b1,       "R1", int'(rx_los), 1);
      chk(tx_bit_start == 1'b0, "R1", int'(tx_bit_start), 0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      for (int k = 0; k < 4; k++) tx_burst(1'b0, 40, k);
      for (int k = 0; k < 3; k++) tx_burst(1'b1, 31, k);
      rx_glitch(24);
      tx_burst(1'b0, 12, 3);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule